// File: doc/BRIEF.md
# Serial Peripheral Shift Engine (Master/Slave)

This block moves words between two FIFOs and a four-wire serial link. It takes one word at a time from a transmit FIFO, serialises it on `sdo`, and builds the bits arriving on `sdi` into words that it writes to a receive FIFO. The FIFOs, the bus interface and the divider that paces the serial clock sit outside the block. The block sees them only through read/write handshakes and a tick strobe.

The block has two roles, chosen by `cfg_master`. As master it drives the serial clock and the active-low select itself. It toggles the clock once per tick from the divider, and it runs as long as the start command is held and the transmit FIFO has data. As slave it follows an external clock and select, and it takes clock polarity and phase from dedicated slave inputs. Both roles use one sequencer with the states IDLE, LOAD, SHIFT and DONE. They also share one shift datapath, in which the bit order can be changed at run time.

Top module: `spi_xfer_engine`

## Requirements
- R1: In master mode a transfer begins only while `start` is 1 and `tx_empty` is 0. Each word pops the transmit FIFO exactly once with a one-cycle `tx_rd` pulse. With `start` low or the FIFO empty, `cs_n_out` stays 1 and nothing is popped.
- R2: `cfg_lsb_first` picks the bit order, and the same order applies to transmit and receive. With 0, bit WORD_W-1 goes out first and the first received bit lands in bit WORD_W-1. With 1, bit 0 goes first both ways.
- R3: In master mode `sck_out` rests at `mst_cpol` whenever no word is shifting. Each word gives exactly WORD_W leading and WORD_W trailing edges, where a leading edge is one that leaves the rest level.
- R4: With phase 0, `sdi` is sampled on leading edges and `sdo` changes on trailing edges. The first bit of a word is already on `sdo` before the first leading edge.
- R5: With phase 1, `sdo` changes on leading edges and `sdi` is sampled on trailing edges.
- R6: Each completed received word is written to the receive FIFO with a one-cycle `rx_wr` pulse. The assembled word appears on `rx_data` during that pulse.
- R7: In master mode `cs_n_out` stays low across back-to-back words. It returns to 1 once a word ends while the FIFO is empty or `start` is low, so there is exactly one select period per burst.
- R8: In slave mode bits move only on edges of `slv_sck`, timed by `slv_cpol`/`slv_cpha`. `mst_cpol`/`mst_cpha` and `gen_tick` have no effect, and `cs_n_out` stays 1.
- R9: In slave mode a word shifts only while `slv_cs_n` is low. If `slv_cs_n` rises before a word is complete, that word is discarded without an `rx_wr`, and the next select period starts from bit 0.
- R10: If `rx_full` is 1 when a word completes, no `rx_wr` is issued and `ovf` becomes 1. `ovf` stays 1 until reset.
- R11: After reset `cs_n_out`=1, `tx_rd`=0, `rx_wr`=0, `ovf`=0, and `sck_out` equals the selected polarity.
- R12: A slave selected while the transmit FIFO is empty shifts out an all-zero word without popping, and it still receives normally.
- R13: With phase 1 and back-to-back words, the push of one word and the pop of the next fall in the same cycle, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 selects master role, 0 slave role |
| cfg_lsb_first | input | 1 | 1 shifts bit 0 first, 0 shifts the top bit first |
| mst_cpol | input | 1 | Master-mode clock rest level |
| mst_cpha | input | 1 | Master-mode clock phase |
| start | input | 1 | Master transfer command (level) |
| gen_tick | input | 1 | One-cycle strobe per serial half period from the divider |
| slv_sck | input | 1 | External serial clock in slave mode (already synchronous to clk) |
| slv_cpol | input | 1 | Slave-mode clock rest level |
| slv_cpha | input | 1 | Slave-mode clock phase |
| slv_cs_n | input | 1 | External active-low select in slave mode |
| sdi | input | 1 | Serial data in |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | WORD_W | Transmit FIFO head word (shown before the read) |
| tx_rd | output | 1 | Transmit FIFO pop |
| rx_full | input | 1 | Receive FIFO full |
| rx_wr | output | 1 | Receive FIFO push |
| rx_data | output | WORD_W | Word being pushed |
| sck_out | output | 1 | Serial clock driven in master mode |
| cs_n_out | output | 1 | Active-low select driven in master mode |
| sdo | output | 1 | Serial data out |
| ovf | output | 1 | Sticky receive-overflow flag |

## Verification
With phase 1, the last sample of a word falls on its final trailing edge. The registered receive push then lands in the LOAD cycle that pops the next transmit word, so both FIFO handshakes fire in the same clock. The bench provokes this with multi-word master bursts in phase 1 and counts the cycles in which `tx_rd` and `rx_wr` are both high. It expects one fewer than the word count, zero in phase 0, and zero whenever the receive side is full. It then compares every captured `sdo` word and every pushed word against its own lists, so a lost pop or a lost push shows up as a wrong word.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_edge_t;

    typedef struct packed {
        logic master;
        logic lsb_first;
        logic cpol;
        logic cpha;
    } lane_cfg_t;

    function automatic logic is_sample(sck_edge_t e, logic cpha);
        return cpha ? e.trail : e.lead;
    endfunction

    function automatic logic is_launch_edge(sck_edge_t e, logic cpha);
        return cpha ? e.lead : e.trail;
    endfunction

endpackage

// File: rtl/spi_edge_sel.sv
module spi_edge_sel
    import spi_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t cfg,
    input  logic      active,
    input  logic      gen_tick,
    input  logic      slv_sck,
    output sck_edge_t edge_o,
    output logic      sck_out
);

    logic half_q;
    logic sck_q;
    logic slv_sck_q;
    logic slv_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b0;
            sck_q     <= cfg.cpol;
            slv_sck_q <= slv_sck;
        end else begin
            slv_sck_q <= slv_sck;
            if (!active || !cfg.master) begin
                half_q <= 1'b0;
                sck_q  <= cfg.cpol;
            end else if (gen_tick) begin
                half_q <= ~half_q;
                sck_q  <= ~sck_q;
            end
        end
    end

    assign slv_chg = slv_sck ^ slv_sck_q;
    assign sck_out = sck_q;

    always_comb begin
        if (cfg.master) begin
            edge_o.lead  = active && gen_tick && !half_q;
            edge_o.trail = active && gen_tick && half_q;
        end else begin
            edge_o.lead  = active && slv_chg && (slv_sck != cfg.cpol);
            edge_o.trail = active && slv_chg && (slv_sck == cfg.cpol);
        end
    end

    AST_MST_LEAD_LEAVES_REST: assert property (@(posedge clk) disable iff (rst)
        (cfg.master && edge_o.lead && $stable(cfg.cpol)) |-> (sck_q == cfg.cpol))
        else $error("leading edge from non-rest level"); // R3

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
    import spi_xfer_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_cfg_t         cfg,
    input  logic              load,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  sck_edge_t         edge_i,
    input  logic              sdi,
    input  logic              rx_full,
    output logic              sdo,
    output logic              word_done,
    output logic              rx_wr,
    output logic [WORD_W-1:0] rx_data,
    output logic              ovf
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] rx_next;
    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  trail_cnt;
    logic [CNT_W-1:0]  smp_cnt;
    logic              smp;
    logic              lch;

    function automatic logic head_of(logic [WORD_W-1:0] v, logic lsb);
        return lsb ? v[0] : v[WORD_W-1];
    endfunction

    function automatic logic [WORD_W-1:0] advance(logic [WORD_W-1:0] v, logic lsb);
        return lsb ? (v >> 1) : (v << 1);
    endfunction

    assign load_word = tx_valid ? tx_word : '0;
    assign smp       = is_sample(edge_i, cfg.cpha);
    assign lch       = is_launch_edge(edge_i, cfg.cpha) &&
                       (cfg.cpha || (trail_cnt != LAST_BIT));
    assign word_done = edge_i.trail && (trail_cnt == LAST_BIT);

    always_comb begin
        if (cfg.lsb_first) rx_next = {sdi, rx_sr[WORD_W-1:1]};
        else               rx_next = {rx_sr[WORD_W-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr     <= '0;
            rx_sr     <= '0;
            rx_data   <= '0;
            trail_cnt <= '0;
            smp_cnt   <= '0;
            sdo       <= 1'b0;
            rx_wr     <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            rx_wr <= 1'b0;
            if (load) begin
                trail_cnt <= '0;
                smp_cnt   <= '0;
                if (cfg.cpha) begin
                    tx_sr <= load_word;
                end else begin
                    sdo   <= head_of(load_word, cfg.lsb_first);
                    tx_sr <= advance(load_word, cfg.lsb_first);
                end
            end else begin
                if (lch) begin
                    sdo   <= head_of(tx_sr, cfg.lsb_first);
                    tx_sr <= advance(tx_sr, cfg.lsb_first);
                end
                if (edge_i.trail) trail_cnt <= trail_cnt + 1'b1;
                if (smp) begin
                    rx_sr   <= rx_next;
                    smp_cnt <= smp_cnt + 1'b1;
                    if (smp_cnt == LAST_BIT) begin
                        rx_data <= rx_next;
                        if (rx_full) ovf   <= 1'b1;
                        else         rx_wr <= 1'b1;
                    end
                end
            end
        end
    end

    AST_SDO_HOLD_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (smp && !load) |=> $stable(sdo))
        else $error("sdo moved on a sampling edge"); // R4

    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf)
        else $error("overflow flag dropped"); // R10

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_wr |=> !rx_wr)
        else $error("receive push longer than one cycle"); // R6

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
    import spi_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        master,
    input  logic        start,
    input  logic        tx_empty,
    input  logic        slv_cs_n,
    input  logic        word_done,
    output xfer_state_t state,
    output logic        load,
    output logic        tx_rd,
    output logic        cs_n_out
);

    xfer_state_t st_q;
    xfer_state_t st_d;
    logic        more;

    assign more = master ? (start && !tx_empty) : !slv_cs_n;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (more) st_d = ST_LOAD;
            ST_LOAD:  st_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!master && slv_cs_n) st_d = ST_DONE;
                else if (word_done)      st_d = more ? ST_LOAD : ST_DONE;
            end
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cs_n_out <= 1'b1;
        end else begin
            st_q <= st_d;
            if (!master)                                   cs_n_out <= 1'b1;
            else if (st_q == ST_IDLE && st_d == ST_LOAD)   cs_n_out <= 1'b0;
            else if (st_q == ST_DONE)                      cs_n_out <= 1'b1;
        end
    end

    assign state = st_q;
    assign load  = (st_q == ST_LOAD);
    assign tx_rd = load && !tx_empty;

    AST_CS_LOW_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (master && st_q == ST_SHIFT) |-> !cs_n_out)
        else $error("select high while shifting"); // R7

    AST_CS_HIGH_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> cs_n_out)
        else $error("select low while idle"); // R7

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_lsb_first,
    input  logic              mst_cpol,
    input  logic              mst_cpha,
    input  logic              start,
    input  logic              gen_tick,
    input  logic              slv_sck,
    input  logic              slv_cpol,
    input  logic              slv_cpha,
    input  logic              slv_cs_n,
    input  logic              sdi,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_rd,
    input  logic              rx_full,
    output logic              rx_wr,
    output logic [WORD_W-1:0] rx_data,
    output logic              sck_out,
    output logic              cs_n_out,
    output logic              sdo,
    output logic              ovf
);

    lane_cfg_t   cfg;
    sck_edge_t   edges;
    xfer_state_t st;
    logic        load;
    logic        word_done;

    always_comb begin
        cfg.master    = cfg_master;
        cfg.lsb_first = cfg_lsb_first;
        cfg.cpol      = cfg_master ? mst_cpol : slv_cpol;
        cfg.cpha      = cfg_master ? mst_cpha : slv_cpha;
    end

    spi_xfer_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .master    (cfg_master),
        .start     (start),
        .tx_empty  (tx_empty),
        .slv_cs_n  (slv_cs_n),
        .word_done (word_done),
        .state     (st),
        .load      (load),
        .tx_rd     (tx_rd),
        .cs_n_out  (cs_n_out)
    );

    spi_edge_sel u_edge (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .active   (st == ST_SHIFT),
        .gen_tick (gen_tick),
        .slv_sck  (slv_sck),
        .edge_o   (edges),
        .sck_out  (sck_out)
    );

    spi_shift_path #(.WORD_W(WORD_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .load      (load),
        .tx_valid  (!tx_empty),
        .tx_word   (tx_data),
        .edge_i    (edges),
        .sdi       (sdi),
        .rx_full   (rx_full),
        .sdo       (sdo),
        .word_done (word_done),
        .rx_wr     (rx_wr),
        .rx_data   (rx_data),
        .ovf       (ovf)
    );

    AST_SCK_REST_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && st == ST_IDLE && $past(st) == ST_IDLE &&
         $stable(mst_cpol) && $stable(cfg_master)) |-> (sck_out == mst_cpol))
        else $error("serial clock off rest level while idle"); // R3

    AST_START_GATE: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && st == ST_IDLE && (!start || tx_empty)) |=> (st == ST_IDLE))
        else $error("master left idle without start and data"); // R1

endmodule

// File: tb/spi_xfer_engine_tb.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_master = 1'b1, cfg_lsb_first = 1'b0, mst_cpol = 1'b0, mst_cpha = 1'b0;
    logic start = 1'b0, gen_tick = 1'b0;
    logic drv_sck = 1'b0, slv_cpol = 1'b0, slv_cpha = 1'b0, drv_cs_n = 1'b1;
    logic drv_sdi = 1'b0, mdl_sdi = 1'b0, mdl_en = 1'b0, sdi;
    logic tx_empty, tx_rd, rx_full = 1'b0, rx_wr, sck_out, cs_n_out, sdo, ovf;
    logic [W-1:0] tx_data, rx_data;

    always #2.5 clk = ~clk;

    logic [W-1:0] txq [16];
    logic [W-1:0] sl_words [16];
    logic [W-1:0] cap_words [16];
    logic [W-1:0] rxlog [16];
    int tx_wp = 0, tx_rp = 0, rx_n = 0, both_n = 0, cs_rise_n = 0;
    int checks = 0, errors = 0;
    int nwords = 0, mk = 0, ck = 0, tick_cnt = 0;
    logic cs_q = 1'b1, sck_q = 1'b0;

    assign tx_empty = (tx_rp == tx_wp);
    assign tx_data  = txq[tx_rp[3:0]];
    assign sdi      = mdl_en ? mdl_sdi : drv_sdi;

    spi_xfer_engine #(.WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
        .mst_cpol(mst_cpol), .mst_cpha(mst_cpha), .start(start), .gen_tick(gen_tick),
        .slv_sck(drv_sck), .slv_cpol(slv_cpol), .slv_cpha(slv_cpha), .slv_cs_n(drv_cs_n),
        .sdi(sdi), .tx_empty(tx_empty), .tx_data(tx_data), .tx_rd(tx_rd),
        .rx_full(rx_full), .rx_wr(rx_wr), .rx_data(rx_data), .sck_out(sck_out),
        .cs_n_out(cs_n_out), .sdo(sdo), .ovf(ovf)
    );

    // transmit FIFO pointer: nonblocking, like a register
    always @(posedge clk) begin
        if (rst) tx_rp <= 0;
        else if (tx_rd) tx_rp <= tx_rp + 1;
    end

    function automatic logic stream_bit(int k);
        int w = k / W;
        int i = k % W;
        if (w >= nwords) return 1'b0;
        return sl_words[w][cfg_lsb_first ? i : W-1-i];
    endfunction

    // divider ticks, receive log, monitors and the slave-side model
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % 4;
        gen_tick = (tick_cnt == 0);
        if (rst) begin
            rx_n = 0; both_n = 0; cs_rise_n = 0;
        end else begin
            if (rx_wr) begin rxlog[rx_n[3:0]] = rx_data; rx_n++; end
            if (rx_wr && tx_rd) both_n++;
            if (!cs_q && cs_n_out) cs_rise_n++;
            if (mdl_en) begin
                if (cs_q && !cs_n_out) begin
                    mk = 0; ck = 0;
                    if (!mst_cpha) begin mdl_sdi = stream_bit(0); mk = 1; end
                end else if (!cs_n_out && sck_out != sck_q) begin
                    if ((sck_out != mst_cpol) != mst_cpha) begin
                        if (ck / W < 16)
                            cap_words[ck / W][cfg_lsb_first ? ck % W : W-1-(ck % W)] = sdo;
                        ck++;
                    end else begin
                        mdl_sdi = stream_bit(mk); mk++;
                    end
                end
            end
        end
        cs_q  = cs_n_out;
        sck_q = sck_out;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit master, input bit cpol, input bit cpha, input bit lsb,
                            input bit scpol, input bit scpha);
        @(negedge clk);
        rst = 1'b1; start = 1'b0; rx_full = 1'b0; mdl_en = 1'b0;
        cfg_master = master; mst_cpol = cpol; mst_cpha = cpha; cfg_lsb_first = lsb;
        slv_cpol = scpol; slv_cpha = scpha; drv_sck = scpol; drv_cs_n = 1'b1; drv_sdi = 1'b0;
        tx_wp = 0;
        for (int i = 0; i < 16; i++) cap_words[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(cs_n_out == 1'b1, "R11", "cs_n_out after reset", cs_n_out, 1);
        chk(tx_rd == 1'b0 && rx_wr == 1'b0, "R11", "handshakes after reset", {tx_rd, rx_wr}, 0);
        chk(ovf == 1'b0, "R11", "ovf after reset", ovf, 0);
        chk(sck_out == 1'b1, "R11", "sck_out rest after reset", sck_out, 1);
    endtask

    task automatic t_start_gate();
        do_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        txq[0] = 8'h5A; tx_wp = 1;
        repeat (40) @(negedge clk);
        chk(cs_n_out == 1'b1 && tx_rp == 0, "R1", "no start: select/pops", {cs_n_out, 8'(tx_rp)}, 9'h100);
        do_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        start = 1'b1;
        repeat (40) @(negedge clk);
        chk(cs_n_out == 1'b1 && tx_rp == 0, "R1", "empty FIFO: select/pops", {cs_n_out, 8'(tx_rp)}, 9'h100);
        start = 1'b0;
    endtask

    task automatic run_master(input string req, input int nw, input bit cpol, input bit cpha,
                              input bit lsb, input bit full, input logic [W-1:0] seed);
        int guard;
        do_reset(1'b1, cpol, cpha, lsb, 1'b0, 1'b0);
        mdl_en = 1'b1; rx_full = full; nwords = nw;
        for (int i = 0; i < nw; i++) begin
            txq[i]      = seed + W'(i * 8'h53);
            sl_words[i] = ~seed ^ W'(i * 8'h29 + 1);
        end
        tx_wp = nw;
        start = 1'b1;
        guard = 0;
        while (cs_n_out && guard < 100) begin @(negedge clk); guard++; end
        guard = 0;
        while (!cs_n_out && guard < 3000) begin @(negedge clk); guard++; end
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(tx_rp == nw, "R1", "words popped", tx_rp, nw);
        for (int i = 0; i < nw; i++)
            chk(cap_words[i] == txq[i], req, "word seen on sdo", cap_words[i], txq[i]);
        chk(cs_rise_n == 1, "R7", "select periods per burst", cs_rise_n, 1);
        chk(sck_out == cpol, "R3", "sck rest level after burst", sck_out, cpol);
        chk(ck == nw * W, "R3", "sampling edges seen", ck, nw * W);
        if (full) begin
            chk(rx_n == 0, "R10", "pushes while full", rx_n, 0);
            chk(ovf == 1'b1, "R10", "ovf after drop", ovf, 1);
            rx_full = 1'b0;
            repeat (10) @(negedge clk);
            chk(ovf == 1'b1, "R10", "ovf sticky", ovf, 1);
        end else begin
            chk(rx_n == nw, "R6", "words pushed", rx_n, nw);
            for (int i = 0; i < nw; i++)
                chk(rxlog[i] == sl_words[i], "R6", "received word", rxlog[i], sl_words[i]);
            chk(both_n == (cpha ? nw - 1 : 0), "R13", "push and pop in one cycle", both_n, cpha ? nw - 1 : 0);
        end
        mdl_en = 1'b0;
    endtask

    // bench acts as the external master; base selects the word slots used
    task automatic slv_run(input int base, input int nw, input int abort_at);
        int k, w, bi;
        drv_sck = slv_cpol;
        repeat (3) @(negedge clk);
        drv_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (k = 0; k < nw * W; k++) begin
            if (abort_at >= 0 && k == abort_at) break;
            w  = base + k / W;
            bi = cfg_lsb_first ? k % W : W-1-(k % W);
            if (!slv_cpha) begin
                drv_sdi = sl_words[w][bi];
                drv_sck = ~drv_sck;
                cap_words[w][bi] = sdo;
                repeat (2) @(negedge clk);
                drv_sck = ~drv_sck;
                repeat (2) @(negedge clk);
            end else begin
                drv_sck = ~drv_sck;
                repeat (2) @(negedge clk);
                drv_sdi = sl_words[w][bi];
                cap_words[w][bi] = sdo;
                drv_sck = ~drv_sck;
                repeat (2) @(negedge clk);
            end
        end
        drv_cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic run_slave(input int nw, input bit scpol, input bit scpha, input bit lsb,
                             input logic [W-1:0] seed);
        // master-side settings deliberately opposite to show they are ignored
        do_reset(1'b0, ~scpol, ~scpha, lsb, scpol, scpha);
        for (int i = 0; i < nw; i++) begin
            txq[i]      = seed ^ W'(i * 8'h6D);
            sl_words[i] = seed + W'(i * 8'h35 + 7);
        end
        tx_wp = nw;
        start = 1'b1;
        slv_run(0, nw, -1);
        start = 1'b0;
        chk(tx_rp == nw, "R8", "slave pops", tx_rp, nw);
        for (int i = 0; i < nw; i++) begin
            chk(cap_words[i] == txq[i], "R8", "slave sdo word", cap_words[i], txq[i]);
            chk(rxlog[i] == sl_words[i], "R8", "slave received word", rxlog[i], sl_words[i]);
        end
        chk(rx_n == nw, "R8", "slave pushes", rx_n, nw);
        chk(cs_n_out == 1'b1, "R8", "cs_n_out in slave mode", cs_n_out, 1);
    endtask

    task automatic t_slave_abort();
        do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        txq[0] = 8'hC3; txq[1] = 8'h96;
        sl_words[0] = 8'hFF; sl_words[1] = 8'h4E;
        tx_wp = 1;
        slv_run(0, 1, 3);
        chk(rx_n == 0, "R9", "push after aborted word", rx_n, 0);
        chk(tx_rp == 1, "R9", "pops for aborted word", tx_rp, 1);
        tx_wp = 2;
        slv_run(1, 1, -1);
        chk(rx_n == 1 && rxlog[0] == sl_words[1], "R9", "word after abort", rxlog[0], sl_words[1]);
        chk(cap_words[1] == txq[1], "R9", "sdo word after abort", cap_words[1], txq[1]);
    endtask

    task automatic t_slave_empty();
        do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        sl_words[0] = 8'hB1;
        slv_run(0, 1, -1);
        chk(cap_words[0] == '0, "R12", "sdo word with empty FIFO", cap_words[0], 0);
        chk(tx_rp == 0, "R12", "pops with empty FIFO", tx_rp, 0);
        chk(rx_n == 1 && rxlog[0] == 8'hB1, "R12", "receive with empty FIFO", rxlog[0], 8'hB1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_start_gate();
        run_master("R4", 3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h9C);
        run_master("R5", 3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h17);
        run_master("R13", 4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hE2);
        run_master("R2", 2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h41);
        run_master("R10", 2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h6B);
        run_slave(2, 1'b0, 1'b0, 1'b0, 8'hA7);
        run_slave(2, 1'b1, 1'b1, 1'b1, 8'h3E);
        t_slave_abort();
        t_slave_empty();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule